// File: doc/BRIEF.md
# Parallel DAC Write Sequencer

This block sits on the host side of a double-buffered parallel digital-to-analog converter. It takes a 12-bit output code over a valid/ready handshake. It then produces the active-low strobes that move the code into the converter's input registers and from there into its output register. It drives the data lines, a write strobe, separate low-byte and high-byte selects, a load strobe and a clear strobe. Every pulse is held for a whole number of clock cycles. That number is computed from the converter's minimum timing rules and the clock period, and rounded up.

The block supports two bus arrangements, chosen per transfer by a mode input. In wide mode, both selects fall together with the write strobe for one combined write. In narrow mode the converter's upper four data pins are wired to its lowest four, and the transfer takes two writes. The low byte goes first. After a one-cycle pause with every strobe high, the upper nibble follows on the low data lines. Both modes finish with a load pulse, because the converter's analogue output only moves on that load pulse. A clear request produces a timed clear pulse, but never in the middle of a transfer.

Top module: `dac_wr_seq`

## Requirements
- R1: During reset and after its release, every strobe output is high, the data lines are zero, and `in_ready` is low during reset and high once the block has left reset.
- R2: A wide-mode transfer (`mode_narrow`=0) holds `dac_wr_n`, `dac_cs_lo_n` and `dac_cs_hi_n` low together for W cycles, starting on the clock after acceptance, with the full 12-bit code on `dac_d`.
- R3: A narrow-mode transfer (`mode_narrow`=1) first holds `dac_wr_n` and `dac_cs_lo_n` low for W cycles, with `dac_cs_hi_n` high, code bits 7:0 on `dac_d[7:0]` and `dac_d[11:8]` zero.
- R4: In narrow mode, the low-byte write is followed by exactly one cycle with all strobes high and the data lines unchanged. Then `dac_wr_n` and `dac_cs_hi_n` are held low for W cycles with code bits 11:8 on `dac_d[3:0]` and `dac_d[11:4]` zero.
- R5: The cycle after the last write, `dac_ldac_n` goes low for L cycles while the write strobe and both selects stay high and the data lines keep their last value.
- R6: `in_ready` falls on the clock that accepts a code and rises on the same clock that returns `dac_ldac_n` high. The data lines return to zero on that clock.
- R7: W = max(ceil(tWR/Tclk), ceil(tCS/Tclk), ceil(tDS/Tclk)), L = ceil(tLD/Tclk) and C = ceil(tCLR/Tclk). Each count is at least 1, and an exact multiple of the period is not rounded up.
- R8: A clear request raised while the block is idle drives `dac_clr_n` low for C cycles, starting on the next clock, with `in_ready` low throughout. `in_ready` rises as the clear pulse ends.
- R9: A clear request raised during a transfer is held. After the load pulse there is one idle cycle with `in_ready` low, and then the C-cycle clear pulse.
- R10: While `in_ready` is low, `in_valid`, `in_code` and `mode_narrow` have no effect. The transfer in progress keeps the code and mode captured at acceptance.
- R11: Strobe phases never overlap: the load strobe is never low while the write strobe or a select is low, and the clear strobe is never low while any other strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Code offered |
| in_ready | output | 1 | Code accepted when high together with in_valid |
| in_code | input | 12 | Output code to send |
| mode_narrow | input | 1 | 1: two writes on an 8-bit bus; 0: one 12-bit write |
| clr_req | input | 1 | Request a clear pulse |
| dac_d | output | 12 | Converter data lines |
| dac_wr_n | output | 1 | Write strobe, active low |
| dac_cs_lo_n | output | 1 | Low-byte select, active low |
| dac_cs_hi_n | output | 1 | High-nibble select, active low |
| dac_ldac_n | output | 1 | Load strobe, active low |
| dac_clr_n | output | 1 | Clear strobe, active low |

## Verification
The bench builds the block with a 15 ns clock, the 40 ns write, select and setup limits, a 50 ns load limit and a 60 ns clear limit. That gives W = 3 (2.67 rounded up), L = 4 (3.33 rounded up) and C = 4 (an exact multiple, left as it is). Because the three counts differ, a phase that uses the wrong count shows up, and both branches of the rounding are exercised. Random codes in both modes are mixed with clear requests during a transfer and with new offers made while the block is busy.

// File: rtl/dac_wr_pkg.sv
`timescale 1ns/1ps
package dac_wr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WALL,
    PH_WLO,
    PH_GAP,
    PH_WHI,
    PH_LOAD,
    PH_CLR
  } phase_e;

  function automatic int unsigned cyc_ceil(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac_phase_timer.sv
`timescale 1ns/1ps
module dac_phase_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/dac_wr_ctrl.sv
`timescale 1ns/1ps
module dac_wr_ctrl
  import dac_wr_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CNT_W  = 3,
  parameter int unsigned W_CYC  = 4,
  parameter int unsigned L_CYC  = 4,
  parameter int unsigned C_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_code,
  input  logic              mode_narrow,
  input  logic              clr_req,
  input  logic              tmr_done,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output phase_e            ph_d,
  output logic [DATA_W-1:0] code_d,
  output logic              in_ready
);
  phase_e            ph_q;
  logic              pend_q, pend_d;
  logic              rdy_q, rdy_d;
  logic [DATA_W-1:0] code_q;
  logic              accept;

  assign accept = in_valid && rdy_q;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (accept)                 ph_d = mode_narrow ? PH_WLO : PH_WALL;
        else if (clr_req || pend_q) ph_d = PH_CLR;
      end
      PH_WALL: if (tmr_done) ph_d = PH_LOAD;
      PH_WLO:  if (tmr_done) ph_d = PH_GAP;
      PH_GAP:  if (tmr_done) ph_d = PH_WHI;
      PH_WHI:  if (tmr_done) ph_d = PH_LOAD;
      PH_LOAD: if (tmr_done) ph_d = PH_IDLE;
      PH_CLR:  if (tmr_done) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = (ph_d != ph_q);
    unique case (ph_d)
      PH_WALL, PH_WLO, PH_WHI: tmr_val = CNT_W'(W_CYC - 1);
      PH_LOAD:                 tmr_val = CNT_W'(L_CYC - 1);
      PH_CLR:                  tmr_val = CNT_W'(C_CYC - 1);
      default:                 tmr_val = '0;
    endcase
  end

  always_comb begin
    pend_d = (pend_q || clr_req) && (ph_d != PH_CLR);
    rdy_d  = (ph_d == PH_IDLE) && !pend_d;
    code_d = accept ? in_code : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      pend_q <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      pend_q <= pend_d;
      rdy_q  <= rdy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= '0;
    else if (accept) code_q <= in_code;
  end

  assign in_ready = rdy_q;
endmodule

// File: rtl/dac_pin_drive.sv
`timescale 1ns/1ps
module dac_pin_drive
  import dac_wr_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned LO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            ph_d,
  input  logic [DATA_W-1:0] code_d,
  output logic [DATA_W-1:0] dac_d,
  output logic              dac_wr_n,
  output logic              dac_cs_lo_n,
  output logic              dac_cs_hi_n,
  output logic              dac_ldac_n,
  output logic              dac_clr_n
);
  localparam int unsigned HI_W = DATA_W - LO_W;

  logic [DATA_W-1:0] lo_field, hi_field, bus_n, bus_q;
  logic wr_n_d, lo_n_d, hi_n_d, ld_n_d, cl_n_d;
  logic wr_q, lo_q, hi_q, ld_q, cl_q;

  always_comb begin
    lo_field           = '0;
    lo_field[LO_W-1:0] = code_d[LO_W-1:0];
    hi_field           = '0;
    hi_field[HI_W-1:0] = code_d[DATA_W-1:LO_W];
  end

  always_comb begin
    wr_n_d = 1'b1;
    lo_n_d = 1'b1;
    hi_n_d = 1'b1;
    ld_n_d = 1'b1;
    cl_n_d = 1'b1;
    bus_n  = bus_q;
    unique case (ph_d)
      PH_IDLE: bus_n = '0;
      PH_CLR: begin
        bus_n  = '0;
        cl_n_d = 1'b0;
      end
      PH_WALL: begin
        wr_n_d = 1'b0;
        lo_n_d = 1'b0;
        hi_n_d = 1'b0;
        bus_n  = code_d;
      end
      PH_WLO: begin
        wr_n_d = 1'b0;
        lo_n_d = 1'b0;
        bus_n  = lo_field;
      end
      PH_WHI: begin
        wr_n_d = 1'b0;
        hi_n_d = 1'b0;
        bus_n  = hi_field;
      end
      PH_LOAD: ld_n_d = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q <= '0;
      wr_q  <= 1'b1;
      lo_q  <= 1'b1;
      hi_q  <= 1'b1;
      ld_q  <= 1'b1;
      cl_q  <= 1'b1;
    end else begin
      bus_q <= bus_n;
      wr_q  <= wr_n_d;
      lo_q  <= lo_n_d;
      hi_q  <= hi_n_d;
      ld_q  <= ld_n_d;
      cl_q  <= cl_n_d;
    end
  end

  assign dac_d       = bus_q;
  assign dac_wr_n    = wr_q;
  assign dac_cs_lo_n = lo_q;
  assign dac_cs_hi_n = hi_q;
  assign dac_ldac_n  = ld_q;
  assign dac_clr_n   = cl_q;
endmodule

// File: rtl/dac_wr_seq.sv
`timescale 1ns/1ps
module dac_wr_seq
  import dac_wr_pkg::*;
#(
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned LO_W     = 8,
  parameter int unsigned SYNC_N   = 2,
  parameter int unsigned CLK_PS   = 10000,
  parameter int unsigned T_WR_PS  = 40000,
  parameter int unsigned T_CS_PS  = 40000,
  parameter int unsigned T_DS_PS  = 40000,
  parameter int unsigned T_LD_PS  = 40000,
  parameter int unsigned T_CLR_PS = 40000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_code,
  input  logic              mode_narrow,
  input  logic              clr_req,
  output logic [DATA_W-1:0] dac_d,
  output logic              dac_wr_n,
  output logic              dac_cs_lo_n,
  output logic              dac_cs_hi_n,
  output logic              dac_ldac_n,
  output logic              dac_clr_n
);
  localparam int unsigned W_CYC = max2(max2(cyc_ceil(T_WR_PS, CLK_PS), cyc_ceil(T_CS_PS, CLK_PS)),
                                       cyc_ceil(T_DS_PS, CLK_PS));
  localparam int unsigned L_CYC = cyc_ceil(T_LD_PS, CLK_PS);
  localparam int unsigned C_CYC = cyc_ceil(T_CLR_PS, CLK_PS);
  localparam int unsigned MAX_CYC = max2(max2(W_CYC, L_CYC), C_CYC);
  localparam int unsigned CNT_W = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic [SYNC_N-1:0] sync_q;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = sync_q[SYNC_N-1];

  phase_e            ph_d;
  logic [DATA_W-1:0] code_d;
  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_val;

  dac_wr_ctrl #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .W_CYC(W_CYC), .L_CYC(L_CYC), .C_CYC(C_CYC)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_int_n), .in_valid(in_valid), .in_code(in_code),
    .mode_narrow(mode_narrow), .clr_req(clr_req), .tmr_done(tmr_done),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .ph_d(ph_d), .code_d(code_d),
    .in_ready(in_ready)
  );

  dac_phase_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk(clk), .rst_n(rst_int_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  dac_pin_drive #(.DATA_W(DATA_W), .LO_W(LO_W)) pins_i (
    .clk(clk), .rst_n(rst_int_n), .ph_d(ph_d), .code_d(code_d), .dac_d(dac_d),
    .dac_wr_n(dac_wr_n), .dac_cs_lo_n(dac_cs_lo_n), .dac_cs_hi_n(dac_cs_hi_n),
    .dac_ldac_n(dac_ldac_n), .dac_clr_n(dac_clr_n)
  );
endmodule

// File: rtl/dac_wr_seq_chk.sv
`timescale 1ns/1ps
module dac_wr_seq_chk #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned LO_W   = 8,
  parameter int unsigned W_CYC  = 4,
  parameter int unsigned L_CYC  = 4,
  parameter int unsigned C_CYC  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic [DATA_W-1:0] dac_d,
  input logic              dac_wr_n,
  input logic              dac_cs_lo_n,
  input logic              dac_cs_hi_n,
  input logic              dac_ldac_n,
  input logic              dac_clr_n
);
  localparam int unsigned HI_W = DATA_W - LO_W;

  logic [15:0] wr_run, ld_run, cl_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_run <= '0;
      ld_run <= '0;
      cl_run <= '0;
    end else begin
      wr_run <= dac_wr_n   ? '0 : wr_run + 16'd1;
      ld_run <= dac_ldac_n ? '0 : ld_run + 16'd1;
      cl_run <= dac_clr_n  ? '0 : cl_run + 16'd1;
    end
  end

  a_r7_wr_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n) |-> wr_run == 16'(W_CYC));
  a_r5_ldac_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_ldac_n) |-> ld_run == 16'(L_CYC));
  a_r8_clr_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_clr_n) |-> cl_run == 16'(C_CYC));
  a_r11_ldac_alone: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_ldac_n |-> (dac_wr_n && dac_cs_lo_n && dac_cs_hi_n && dac_clr_n));
  a_r11_clr_alone: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_clr_n |-> (dac_wr_n && dac_cs_lo_n && dac_cs_hi_n && dac_ldac_n && !in_ready));
  a_r2_wr_has_select: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_n |-> (!dac_cs_lo_n || !dac_cs_hi_n));
  a_r6_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (dac_wr_n && dac_cs_lo_n && dac_cs_hi_n && dac_ldac_n && dac_clr_n));
  a_r10_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_wr_n && $past(!dac_wr_n)) |-> $stable(dac_d));
  a_r3_low_byte_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_cs_lo_n && dac_cs_hi_n) |-> dac_d[DATA_W-1:LO_W] == '0);
  a_r4_nibble_low_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_cs_lo_n && !dac_cs_hi_n) |-> dac_d[DATA_W-1:HI_W] == '0);
endmodule

bind dac_wr_seq dac_wr_seq_chk #(
  .DATA_W(DATA_W), .LO_W(LO_W), .W_CYC(W_CYC), .L_CYC(L_CYC), .C_CYC(C_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .dac_d(dac_d),
  .dac_wr_n(dac_wr_n), .dac_cs_lo_n(dac_cs_lo_n), .dac_cs_hi_n(dac_cs_hi_n),
  .dac_ldac_n(dac_ldac_n), .dac_clr_n(dac_clr_n)
);

// File: tb/dac_wr_seq_tb_top.sv
`timescale 1ns/1ps
module dac_wr_seq_tb_top;
  localparam int CLK_NS   = 15;
  localparam int CLK_PS   = CLK_NS * 1000;
  localparam int T_W_PS   = 40000;
  localparam int T_LD_PS  = 50000;
  localparam int T_CLR_PS = 60000;
  localparam int W = (T_W_PS + CLK_PS - 1) / CLK_PS;
  localparam int L = (T_LD_PS + CLK_PS - 1) / CLK_PS;
  localparam int C = (T_CLR_PS + CLK_PS - 1) / CLK_PS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [11:0] in_code = '0;
  logic mode_narrow = 1'b0;
  logic clr_req = 1'b0;
  logic [11:0] dac_d;
  logic dac_wr_n, dac_cs_lo_n, dac_cs_hi_n, dac_ldac_n, dac_clr_n;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #(CLK_NS / 2.0) clk = ~clk;

  dac_wr_seq #(
    .CLK_PS(CLK_PS), .T_WR_PS(T_W_PS), .T_CS_PS(T_W_PS), .T_DS_PS(T_W_PS),
    .T_LD_PS(T_LD_PS), .T_CLR_PS(T_CLR_PS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .mode_narrow(mode_narrow), .clr_req(clr_req),
    .dac_d(dac_d), .dac_wr_n(dac_wr_n), .dac_cs_lo_n(dac_cs_lo_n),
    .dac_cs_hi_n(dac_cs_hi_n), .dac_ldac_n(dac_ldac_n), .dac_clr_n(dac_clr_n)
  );

  function automatic logic [17:0] vec(bit r, bit w, bit l, bit h, bit d, bit c, logic [11:0] b);
    return {r, w, l, h, d, c, b};
  endfunction

  function automatic logic [17:0] idle_vec();
    return vec(1, 1, 1, 1, 1, 1, 12'h000);
  endfunction

  function automatic logic [17:0] exp_seq(bit m, logic [11:0] code, int k);
    if (!m) begin
      if (k <= W) return vec(0, 0, 0, 0, 1, 1, code);
      return vec(0, 1, 1, 1, 0, 1, code);
    end
    if (k <= W)         return vec(0, 0, 0, 1, 1, 1, {4'h0, code[7:0]});
    if (k == W + 1)     return vec(0, 1, 1, 1, 1, 1, {4'h0, code[7:0]});
    if (k <= 2 * W + 1) return vec(0, 0, 1, 0, 1, 1, {8'h00, code[11:8]});
    return vec(0, 1, 1, 1, 0, 1, {8'h00, code[11:8]});
  endfunction

  function automatic string tag_of(bit m, int k);
    if (!m) begin
      if (k == W) return "R2 R7";
      if (k < W)  return "R2";
      return "R5 R6";
    end
    if (k == W)         return "R3 R7";
    if (k < W)          return "R3";
    if (k <= 2 * W + 1) return "R4";
    return "R5 R6";
  endfunction

  task automatic chk(string tag, logic [17:0] exp);
    logic [17:0] act;
    act = {in_ready, dac_wr_n, dac_cs_lo_n, dac_cs_hi_n, dac_ldac_n, dac_clr_n, dac_d};
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic send(bit m, logic [11:0] code, bit poke, bit clr_mid);
    int n;
    string tg;
    n = m ? (2 * W + 1 + L) : (W + L);
    in_valid = 1'b1;
    mode_narrow = m;
    in_code = code;
    chk("R6 ready before accept", idle_vec());
    @(negedge clk);
    in_valid = poke;
    if (poke) begin
      in_code = ~code;
      mode_narrow = !m;
    end
    clr_req = clr_mid;
    for (int k = 1; k <= n; k++) begin
      tg = tag_of(m, k);
      if (poke) tg = {tg, " R10"};
      chk(tg, exp_seq(m, code, k));
      if (k == n) in_valid = 1'b0;
      @(negedge clk);
      if (k == 1) clr_req = 1'b0;
    end
    if (clr_mid) begin
      chk("R9 idle cycle before clear", vec(0, 1, 1, 1, 1, 1, 12'h000));
      @(negedge clk);
      for (int j = 1; j <= C; j++) begin
        chk("R9 deferred clear", vec(0, 1, 1, 1, 1, 0, 12'h000));
        @(negedge clk);
      end
    end
    chk("R6 ready returns", idle_vec());
  endtask

  task automatic clear_idle();
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    for (int j = 1; j <= C; j++) begin
      chk("R8 clear pulse", vec(0, 1, 1, 1, 1, 0, 12'h000));
      @(negedge clk);
    end
    chk("R8 clear done", idle_vec());
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R1 in reset", vec(0, 1, 1, 1, 1, 1, 12'h000));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset", idle_vec());

    send(0, 12'hFFF, 0, 0);
    send(0, 12'h000, 0, 0);
    send(1, 12'hA5C, 0, 0);
    send(1, 12'hF00, 0, 0);
    send(1, 12'h0FF, 1, 0);
    send(0, 12'h3C6, 1, 0);
    clear_idle();
    send(0, 12'h123, 0, 1);
    send(1, 12'h9E7, 1, 1);

    for (int i = 0; i < 60; i++) begin
      if ($urandom % 6 == 0) clear_idle();
      send(1'($urandom % 2), 12'($urandom % 4096), ($urandom % 3) == 0, ($urandom % 5) == 0);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule